// File: doc/BRIEF.md
# Oversampling Nine-Bit Serial Receiver

This block receives asynchronous frames of eleven bit times: a low start bit, nine payload bits sent least significant first, and a final stop bit. The serial line is retimed by a two-flop synchronizer. It is then watched at sixteen ticks per bit. The tick rate comes from the system clock divided by 4 or by 2, so one bit lasts 64 or 32 clocks.

A falling edge seen while the receiver is waiting restarts the sixteen-step phase counter, so that bit boundaries line up with the counter wrapping. In every bit, the line is sampled at phases 8, 9 and 10, and the bit is taken as the majority of the three samples. If the start bit is voted high, the frame is dropped. After the stop bit is decided, the first eight payload bits go to a byte output and the ninth payload bit goes to a separate flag. A sticky completion flag is raised at the same time.

This load only happens when the completion flag is clear. When address-filter mode is on, the ninth bit must also be 1. Otherwise the frame is thrown away. The host clears the completion flag with a one-cycle strobe.

Top module: `rx9_top`

## Requirements
- R1: After reset, dataOut is 0x00, bit9Out is 0 and rxDone is 0.
- R2: With rateSel=0 one bit lasts 64 clocks (4 clocks per tick); with rateSel=1 one bit lasts 32 clocks (2 clocks per tick).
- R3: A frame is a 0 start bit, then payload bits p0..p8 with p0 first, then a 1 stop bit. On load, dataOut[i]=p(i) for i in 0..7 and bit9Out=p8.
- R4: Each bit is the 2-of-3 majority of the line sampled at phases 8, 9 and 10 after the bit boundary, so a disturbance that hits only one of those samples does not change the bit.
- R5: If the start bit votes 1, the frame is abandoned without loading, and the next falling edge starts a new frame.
- R6: While rxEn is 0, no frame is received: the outputs and rxDone keep their values.
- R7: A frame that completes while rxDone is 1 is discarded, and dataOut and bit9Out keep their values.
- R8: With mpMode=1, a frame whose ninth bit is 0 is discarded; a frame whose ninth bit is 1 is loaded.
- R9: rxDone is set by a load and stays 1 until a clrDone pulse, which clears it on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEn | input | 1 | Receive enable; 0 holds the receiver idle |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| rateSel | input | 1 | 0: bit = 64 clocks, 1: bit = 32 clocks |
| mpMode | input | 1 | Address-filter mode: load only frames whose ninth bit is 1 |
| clrDone | input | 1 | One-cycle strobe that clears rxDone |
| dataOut | output | 8 | Received byte |
| bit9Out | output | 1 | Received ninth bit |
| rxDone | output | 1 | Sticky receive-complete flag |

## Verification
Frames are sent at both rates with different byte patterns and both values of the ninth bit. This shows that the bit order and the rate divisor are right.

A frame that has a short pulse of the wrong polarity in the middle of every bit separates a majority vote from a single mid-bit sample. A short low glitch on the line separates start-bit rejection from a receiver that trusts any falling edge.

Further frames are sent while the flag is already set, with address-filter mode on and the ninth bit at each value, and with the enable low. These show that each gating rule leaves the outputs untouched when it should.

// File: rtl/rx9_pkg.sv
package rx9_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rxState_t;

  typedef struct packed {
    logic holdA;   // capture sample at phase 8
    logic holdB;   // capture sample at phase 9
    logic shift;   // shift voted bit into payload register
    logic load;    // move payload to outputs and raise done
  } rxStrobe_t;

endpackage

// File: rtl/rx9_datapath.sv
module rx9_datapath
  import rx9_pkg::*;
#(
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              rateSel,
  input  logic              clrDone,
  input  rxStrobe_t         strobe,
  output logic              tick,
  output logic              fallTick,
  output logic              voteBit,
  output logic              ninthPend,
  output logic [DATA_W-1:0] dataOut,
  output logic              bit9Out,
  output logic              rxDone
);

  localparam int PRE_W = $clog2(SLOW_DIV) + 1;
  localparam int SR_W  = DATA_W + 1;
  localparam logic [PRE_W-1:0] SLOW_LIM = PRE_W'(SLOW_DIV - 1);
  localparam logic [PRE_W-1:0] FAST_LIM = PRE_W'(FAST_DIV - 1);

  logic [1:0]       syncQ;
  logic             lineS;
  logic             lineD;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLim;
  logic             sampA;
  logic             sampB;
  logic [SR_W-1:0]  shiftReg;

  // two-flop synchronizer on the asynchronous line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxLine};
  end
  assign lineS = syncQ[1];

  // oversampling tick prescaler
  assign preLim = rateSel ? FAST_LIM : SLOW_LIM;
  assign tick   = (preCnt >= preLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end

  // R2: ticks are never on back-to-back clocks
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // 1-to-0 detector running at the tick rate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     lineD <= 1'b1;
    else if (tick) lineD <= lineS;
  end
  assign fallTick = tick & lineD & ~lineS;

  // three-sample majority vote
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampA <= 1'b1;
      sampB <= 1'b1;
    end else begin
      if (strobe.holdA) sampA <= lineS;
      if (strobe.holdB) sampB <= lineS;
    end
  end
  assign voteBit = (sampA & sampB) | (sampA & lineS) | (sampB & lineS);

  // payload shift register, first bit ends in the lowest position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strobe.shift) shiftReg <= {voteBit, shiftReg[SR_W-1:1]};
  end
  assign ninthPend = shiftReg[SR_W-1];

  // output buffer and sticky completion flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      bit9Out <= 1'b0;
      rxDone  <= 1'b0;
    end else if (strobe.load) begin
      dataOut <= shiftReg[DATA_W-1:0];
      bit9Out <= shiftReg[SR_W-1];
      rxDone  <= 1'b1;
    end else if (clrDone) begin
      rxDone  <= 1'b0;
    end
  end

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && !clrDone |=> rxDone);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrDone && !strobe.load |=> !rxDone);

  // R7
  data_only_on_new_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> $rose(rxDone));

endmodule

// File: rtl/rx9_control.sv
module rx9_control
  import rx9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxEn,
  input  logic      mpMode,
  input  logic      tick,
  input  logic      fallTick,
  input  logic      voteBit,
  input  logic      doneFlag,
  input  logic      ninthPend,
  output rxStrobe_t strobe
);

  localparam int IDX_W = $clog2(DATA_W + 1) + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W);
  localparam logic [3:0] PH_A = 4'd8;
  localparam logic [3:0] PH_B = 4'd9;
  localparam logic [3:0] PH_V = 4'd10;

  rxState_t         state;
  logic [3:0]       phase;
  logic [IDX_W-1:0] bitIdx;
  logic             busy;
  logic             decide;

  assign busy   = (state != RX_IDLE);
  assign decide = tick && busy && (phase == PH_V);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else if (!rxEn) begin
      state  <= RX_IDLE;
    end else if (tick) begin
      if (!busy) begin
        if (fallTick) begin
          state <= RX_START;
          phase <= 4'd1;
        end
      end else begin
        phase <= phase + 4'd1;
        if (phase == PH_V) begin
          unique case (state)
            RX_START: begin
              if (voteBit) state <= RX_IDLE;
              else begin
                state  <= RX_DATA;
                bitIdx <= '0;
              end
            end
            RX_DATA: begin
              if (bitIdx == LAST_IDX) state <= RX_STOP;
              else                    bitIdx <= bitIdx + 1'b1;
            end
            RX_STOP: state <= RX_IDLE;
            default: state <= RX_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.holdA = tick && busy && (phase == PH_A);
    strobe.holdB = tick && busy && (phase == PH_B);
    strobe.shift = decide && (state == RX_DATA);
    strobe.load  = decide && (state == RX_STOP) && !doneFlag
                   && (!mpMode || ninthPend);
  end

  // R6
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> state == RX_IDLE);

  // R3
  bit_index_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= LAST_IDX);

  // R4
  one_sample_per_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.holdA, strobe.holdB, decide}) <= 1);

endmodule

// File: rtl/rx9_top.sv
module rx9_top
  import rx9_pkg::*;
#(
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 2,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic              rxLine,
  input  logic              rateSel,
  input  logic              mpMode,
  input  logic              clrDone,
  output logic [DATA_W-1:0] dataOut,
  output logic              bit9Out,
  output logic              rxDone
);

  rxStrobe_t strobe;
  logic      tick;
  logic      fallTick;
  logic      voteBit;
  logic      ninthPend;

  rx9_control #(.DATA_W(DATA_W)) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .rxEn      (rxEn),
    .mpMode    (mpMode),
    .tick      (tick),
    .fallTick  (fallTick),
    .voteBit   (voteBit),
    .doneFlag  (rxDone),
    .ninthPend (ninthPend),
    .strobe    (strobe)
  );

  rx9_datapath #(
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV),
    .DATA_W   (DATA_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .rxLine    (rxLine),
    .rateSel   (rateSel),
    .clrDone   (clrDone),
    .strobe    (strobe),
    .tick      (tick),
    .fallTick  (fallTick),
    .voteBit   (voteBit),
    .ninthPend (ninthPend),
    .dataOut   (dataOut),
    .bit9Out   (bit9Out),
    .rxDone    (rxDone)
  );

  // R8
  mp_ninth_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) && $past(mpMode) |-> bit9Out);

endmodule

// File: tb/test_rx9_top.sv
`timescale 1ns/1ps
module test_rx9_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       rxEn;
  logic       rxLine;
  logic       rateSel;
  logic       mpMode;
  logic       clrDone;
  logic [7:0] dataOut;
  logic       bit9Out;
  logic       rxDone;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rx9_top i_rx9_top (
    .clk     (clk),
    .rstN    (rstN),
    .rxEn    (rxEn),
    .rxLine  (rxLine),
    .rateSel (rateSel),
    .mpMode  (mpMode),
    .clrDone (clrDone),
    .dataOut (dataOut),
    .bit9Out (bit9Out),
    .rxDone  (rxDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input int eData, input int eB9, input int eDone);
    check(dataOut == eData[7:0], {req, " dataOut"}, dataOut, eData);
    check(bit9Out == eB9[0],     {req, " bit9Out"}, bit9Out, eB9);
    check(rxDone == eDone[0],    {req, " rxDone"},  rxDone,  eDone);
  endtask

  // drive one frame; glitch inverts clocks 36..39 of every bit (slow rate only)
  task automatic sendFrame(input logic [7:0] d, input logic b9, input int bitClks, input bit glitch);
    logic [10:0] bits;
    bits = {1'b1, b9, d, 1'b0};
    for (int b = 0; b < 11; b++) begin
      for (int k = 0; k < bitClks; k++) begin
        @(negedge clk);
        rxLine = bits[b] ^ (glitch && k >= 36 && k <= 39);
      end
    end
    @(negedge clk);
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseClear();
    @(negedge clk);
    clrDone = 1'b1;
    @(negedge clk);
    clrDone = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    checkOut("R1", 8'h00, 0, 0);
  endtask

  task automatic testSlowFrame();
    sendFrame(8'hA5, 1'b0, 64, 1'b0);
    checkOut("R3 R2 slow", 8'hA5, 0, 1);
  endtask

  task automatic testSticky();
    repeat (200) @(negedge clk);
    check(rxDone == 1'b1, "R9 held", rxDone, 1);
    pulseClear();
    checkOut("R9 cleared", 8'hA5, 0, 0);
  endtask

  task automatic testFastFrame();
    rateSel = 1'b1;
    sendFrame(8'h3C, 1'b1, 32, 1'b0);
    checkOut("R2 R3 fast", 8'h3C, 1, 1);
    pulseClear();
    rateSel = 1'b0;
  endtask

  task automatic testHeld();
    sendFrame(8'h11, 1'b0, 64, 1'b0);
    checkOut("R7 first", 8'h11, 0, 1);
    sendFrame(8'h22, 1'b1, 64, 1'b0);
    checkOut("R7 discarded", 8'h11, 0, 1);
    pulseClear();
  endtask

  task automatic testMultiproc();
    mpMode = 1'b1;
    sendFrame(8'h77, 1'b0, 64, 1'b0);
    checkOut("R8 ninth=0 dropped", 8'h11, 0, 0);
    sendFrame(8'h88, 1'b1, 64, 1'b0);
    checkOut("R8 ninth=1 loaded", 8'h88, 1, 1);
    pulseClear();
    mpMode = 1'b0;
  endtask

  task automatic testVote();
    sendFrame(8'h5A, 1'b1, 64, 1'b1);
    checkOut("R4 majority", 8'h5A, 1, 1);
    pulseClear();
  endtask

  task automatic testFalseStart();
    @(negedge clk);
    rxLine = 1'b0;
    repeat (12) @(negedge clk);
    rxLine = 1'b1;
    repeat (800) @(negedge clk);
    checkOut("R5 aborted", 8'h5A, 1, 0);
    sendFrame(8'hC3, 1'b0, 64, 1'b0);
    checkOut("R5 rearmed", 8'hC3, 0, 1);
    pulseClear();
  endtask

  task automatic testDisabled();
    rxEn = 1'b0;
    sendFrame(8'h99, 1'b1, 64, 1'b0);
    checkOut("R6 disabled", 8'hC3, 0, 0);
    rxEn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; rxEn = 1'b1; rxLine = 1'b1;
    rateSel = 1'b0; mpMode = 1'b0; clrDone = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testSlowFrame();
    testSticky();
    testFastFrame();
    testHeld();
    testMultiproc();
    testVote();
    testFalseStart();
    testDisabled();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule